// File: doc/BRIEF.md
# Block-Edge Deblocking Filter Sequencer

This block smooths the seams between 8x8 blocks of one reconstructed 8-bit luma tile. The tile sits in a pixel store inside the block. A host fills the store through a write port, sets a filter strength, and pulses start. The block then walks every internal block boundary and rewrites the four pixels that straddle it, one four-pixel segment per clock. When the walk ends it raises done for one cycle, and the host reads the filtered tile back through a combinational read port.

The walk covers all horizontal boundaries first, from the top boundary down, with each boundary scanned left to right. It then covers the vertical boundaries from left to right, with each one scanned top to bottom. Because of this order, every horizontal boundary reads pixels that no vertical filtering has touched yet. Boundaries on the tile border are never filtered. Each segment applies a correction whose size follows a ramp controlled by the strength value, and every result is clipped to the 8-bit range.

Top module: `edge_deblock`

## Requirements
- R1: During reset and on the first cycle after it, busy and done are both 0. The strength register resets to 0.
- R2: A start pulse sampled while busy is 0 begins a pass. From the next cycle busy stays 1 for exactly NSEG = (BLK_ROWS-1)*W + (BLK_COLS-1)*H cycles, one segment per cycle, where W = 8*BLK_COLS and H = 8*BLK_ROWS. In the cycle after that, done is 1 for one cycle and busy is 0.
- R3: A start pulse sampled while busy is 1 is ignored. The pass is not restarted, and done comes at the time set by the first start.
- R4: Only pixels within two positions of an internal boundary (a multiple of 8 that is not 0, W or H) can change. Pixels next to the tile border and pixels deeper inside a block keep their values.
- R5: For a segment A, B | C, D (A and B above or left of the boundary), d = floor((A - 4B + 4C - D)/8). With strength S, the magnitude m is |d| when |d| < S, 2S - |d| when S <= |d| < 2S, and 0 otherwise. The correction d1 is m with the sign of d.
- R6: B' = B + d1 and C' = C - d1. Let d2 = floor((A - D)/4), limited to the range [-floor(m/2), +floor(m/2)]. Then A' = A - d2 and D' = D + d2.
- R7: Each of the four results of R6 is clipped to 0..255 before it is stored.
- R8: Horizontal boundaries are filtered top to bottom, each left to right, before any vertical boundary. Vertical boundaries are then filtered left to right, each top to bottom, and they read the pixels already filtered across horizontal boundaries.
- R9: A strength write (cfgWe) is taken while busy is 0, including in the same cycle as an accepted start. It is ignored while busy is 1.
- R10: A pixel write (pixWe) stores pixWdata at address y*W + x while busy is 0, including in the same cycle as an accepted start, and that pass then uses the new value. It is ignored while busy is 1.
- R11: rdData shows the stored pixel at address rdAddr = y*W + x in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a filtering pass |
| cfgWe | input | 1 | Strength register write enable |
| cfgStrength | input | 8 | New strength value |
| pixWe | input | 1 | Pixel store write enable |
| pixAddr | input | AW (8) | Pixel write address, y*W + x |
| pixWdata | input | 8 | Pixel value to store |
| rdAddr | input | AW (8) | Pixel read address, y*W + x |
| rdData | output | 8 | Stored pixel at rdAddr |
| busy | output | 1 | High while segments are being filtered |
| done | output | 1 | One-cycle pulse when a pass ends |

## Verification
A host write and the acceptance of start can fall on the same clock edge. In one test the bench drives a pixel write next to both a horizontal and a vertical boundary, a new strength value and start, all in the same cycle. The golden model computes the result from the new pixel and the new strength, so the test fails if the design drops the write or lets it land after the pass has begun. The opposite case is also covered. In another test the same three inputs arrive in the middle of a pass, where all of them must be discarded: the bench checks that the done time is unchanged and that the untouched pixel still holds its loaded value.

// File: rtl/edge_deblock_pkg.sv
package edge_deblock_pkg;

  localparam int BLK_DIM = 8;
  localparam int IDX_W   = 12;
  localparam int TAPS    = 4;

  typedef struct packed {
    logic             step;
    logic             vert;
    logic [IDX_W-1:0] edgeIdx;
    logic [IDX_W-1:0] pos;
  } seqCmd_t;

  function automatic logic [7:0] clipPix(input logic signed [11:0] v);
    logic [7:0] r;
    if (v < 12'sd0) r = 8'd0;
    else if (v > 12'sd255) r = 8'd255;
    else r = v[7:0];
    return r;
  endfunction

endpackage

// File: rtl/edge_deblock_kernel.sv
module edge_deblock_kernel
  import edge_deblock_pkg::*;
(
  input  logic [7:0] pixA,
  input  logic [7:0] pixB,
  input  logic [7:0] pixC,
  input  logic [7:0] pixD,
  input  logic [7:0] strength,
  output logic [7:0] outA,
  output logic [7:0] outB,
  output logic [7:0] outC,
  output logic [7:0] outD
);

  logic signed [11:0] sa, sb, sc, sd;
  logic signed [11:0] sumV, dV, absD, sVal, twoS, mag, d1;
  logic signed [11:0] d2Raw, lim, d2;

  always_comb begin
    sa   = $signed({4'b0, pixA});
    sb   = $signed({4'b0, pixB});
    sc   = $signed({4'b0, pixC});
    sd   = $signed({4'b0, pixD});
    // step measure across the boundary, floored eighth
    sumV = sa - (sb <<< 2) + (sc <<< 2) - sd;
    dV   = sumV >>> 3;
    absD = dV[11] ? -dV : dV;
    // ramp shaped by strength
    sVal = $signed({4'b0, strength});
    twoS = sVal <<< 1;
    if (absD < sVal)      mag = absD;
    else if (absD < twoS) mag = twoS - absD;
    else                  mag = 12'sd0;
    d1 = dV[11] ? -mag : mag;
    // outer pair correction, bounded by half the inner one
    d2Raw = (sa - sd) >>> 2;
    lim   = mag >>> 1;
    if (d2Raw > lim)       d2 = lim;
    else if (d2Raw < -lim) d2 = -lim;
    else                   d2 = d2Raw;
    outA = clipPix(sa - d2);
    outB = clipPix(sb + d1);
    outC = clipPix(sc - d1);
    outD = clipPix(sd + d2);
  end

endmodule

// File: rtl/edge_deblock_ctrl.sv
module edge_deblock_ctrl
  import edge_deblock_pkg::*;
#(
  parameter int BLK_COLS = 2,
  parameter int BLK_ROWS = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output seqCmd_t cmd,
  output logic    busy,
  output logic    done
);

  localparam int W      = BLK_COLS * BLK_DIM;
  localparam int H      = BLK_ROWS * BLK_DIM;
  localparam int NUM_HE = BLK_ROWS - 1;
  localparam int NUM_VE = BLK_COLS - 1;

  typedef enum logic [1:0] {S_IDLE, S_HOR, S_VER, S_FIN} seqState_t;

  seqState_t        state, stateN;
  logic [IDX_W-1:0] edgeCnt, edgeN;
  logic [IDX_W-1:0] posCnt, posN;
  seqState_t        firstPass;

  always_comb begin
    if (NUM_HE > 0)      firstPass = S_HOR;
    else if (NUM_VE > 0) firstPass = S_VER;
    else                 firstPass = S_FIN;
  end

  always_comb begin
    stateN = state;
    edgeN  = edgeCnt;
    posN   = posCnt;
    unique case (state)
      S_IDLE, S_FIN: begin
        if (start) begin
          stateN = firstPass;
          edgeN  = '0;
          posN   = '0;
        end else if (state == S_FIN) begin
          stateN = S_IDLE;
        end
      end
      S_HOR: begin
        if (int'(posCnt) == W - 1) begin
          posN = '0;
          if (int'(edgeCnt) == NUM_HE - 1) begin
            edgeN  = '0;
            stateN = (NUM_VE > 0) ? S_VER : S_FIN;
          end else begin
            edgeN = edgeCnt + 1'b1;
          end
        end else begin
          posN = posCnt + 1'b1;
        end
      end
      S_VER: begin
        if (int'(posCnt) == H - 1) begin
          posN = '0;
          if (int'(edgeCnt) == NUM_VE - 1) begin
            edgeN  = '0;
            stateN = S_FIN;
          end else begin
            edgeN = edgeCnt + 1'b1;
          end
        end else begin
          posN = posCnt + 1'b1;
        end
      end
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      edgeCnt <= '0;
      posCnt  <= '0;
    end else begin
      state   <= stateN;
      edgeCnt <= edgeN;
      posCnt  <= posN;
    end
  end

  always_comb begin
    cmd.step    = (state == S_HOR) || (state == S_VER);
    cmd.vert    = (state == S_VER);
    cmd.edgeIdx = edgeCnt;
    cmd.pos     = posCnt;
  end

  assign busy = cmd.step;
  assign done = (state == S_FIN);

endmodule

// File: rtl/edge_deblock_dp.sv
module edge_deblock_dp
  import edge_deblock_pkg::*;
#(
  parameter int  BLK_COLS = 2,
  parameter int  BLK_ROWS = 2,
  localparam int AW       = $clog2(BLK_COLS * BLK_ROWS * BLK_DIM * BLK_DIM)
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqCmd_t       cmd,
  input  logic          cfgWe,
  input  logic [7:0]    cfgStrength,
  input  logic          pixWe,
  input  logic [AW-1:0] pixAddr,
  input  logic [7:0]    pixWdata,
  input  logic [AW-1:0] rdAddr,
  output logic [7:0]    rdData
);

  localparam int W    = BLK_COLS * BLK_DIM;
  localparam int H    = BLK_ROWS * BLK_DIM;
  localparam int NPIX = W * H;
  localparam int LEAD = BLK_DIM - 2;

  logic [7:0]    pixMem [NPIX];
  logic [7:0]    strengthQ;
  logic [AW-1:0] tapAddr [TAPS];
  logic [7:0]    tapPix  [TAPS];
  logic [7:0]    newPix  [TAPS];

  // segment addresses: two pixels before the boundary, two after
  always_comb begin
    for (int t = 0; t < TAPS; t++) begin
      if (cmd.vert)
        tapAddr[t] = AW'(int'(cmd.pos) * W + int'(cmd.edgeIdx) * BLK_DIM + LEAD + t);
      else
        tapAddr[t] = AW'((int'(cmd.edgeIdx) * BLK_DIM + LEAD + t) * W + int'(cmd.pos));
    end
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign tapPix[t] = pixMem[tapAddr[t]];
  end

  edge_deblock_kernel u_kernel (
    .pixA     (tapPix[0]),
    .pixB     (tapPix[1]),
    .pixC     (tapPix[2]),
    .pixD     (tapPix[3]),
    .strength (strengthQ),
    .outA     (newPix[0]),
    .outB     (newPix[1]),
    .outC     (newPix[2]),
    .outD     (newPix[3])
  );

  always_ff @(posedge clk) begin
    if (cmd.step) begin
      for (int t = 0; t < TAPS; t++) pixMem[tapAddr[t]] <= newPix[t];
    end else if (pixWe) begin
      pixMem[pixAddr] <= pixWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    strengthQ <= '0;
    else if (cfgWe && !cmd.step)  strengthQ <= cfgStrength;
  end

  assign rdData = pixMem[rdAddr];

endmodule

// File: rtl/edge_deblock.sv
module edge_deblock
  import edge_deblock_pkg::*;
#(
  parameter int  BLK_COLS = 2,
  parameter int  BLK_ROWS = 2,
  localparam int AW       = $clog2(BLK_COLS * BLK_ROWS * BLK_DIM * BLK_DIM)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          cfgWe,
  input  logic [7:0]    cfgStrength,
  input  logic          pixWe,
  input  logic [AW-1:0] pixAddr,
  input  logic [7:0]    pixWdata,
  input  logic [AW-1:0] rdAddr,
  output logic [7:0]    rdData,
  output logic          busy,
  output logic          done
);

  seqCmd_t cmd;

  edge_deblock_ctrl #(.BLK_COLS(BLK_COLS), .BLK_ROWS(BLK_ROWS)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .cmd   (cmd),
    .busy  (busy),
    .done  (done)
  );

  edge_deblock_dp #(.BLK_COLS(BLK_COLS), .BLK_ROWS(BLK_ROWS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .cfgWe       (cfgWe),
    .cfgStrength (cfgStrength),
    .pixWe       (pixWe),
    .pixAddr     (pixAddr),
    .pixWdata    (pixWdata),
    .rdAddr      (rdAddr),
    .rdData      (rdData)
  );

endmodule

// File: rtl/edge_deblock_chk.sv
module edge_deblock_chk #(
  parameter int BLK_COLS = 2,
  parameter int BLK_ROWS = 2
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done
);

  localparam int NSEG = (BLK_ROWS - 1) * BLK_COLS * 8 + (BLK_COLS - 1) * BLK_ROWS * 8;

  logic [15:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else       busyRun <= busy ? busyRun + 16'd1 : 16'd0;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!busy && !done));

  // R2
  seg_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyRun == 16'(NSEG)));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R3
  busy_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

endmodule

bind edge_deblock edge_deblock_chk #(.BLK_COLS(BLK_COLS), .BLK_ROWS(BLK_ROWS)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .busy  (busy),
  .done  (done)
);

// File: tb/edge_deblock_tb.sv
module edge_deblock_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BC   = 2;
  localparam int BR   = 2;
  localparam int W    = BC * 8;
  localparam int H    = BR * 8;
  localparam int NPIX = W * H;
  localparam int AW   = $clog2(NPIX);
  localparam int NSEG = (BR - 1) * W + (BC - 1) * H;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          cfgWe = 1'b0;
  logic [7:0]    cfgStrength = '0;
  logic          pixWe = 1'b0;
  logic [AW-1:0] pixAddr = '0;
  logic [7:0]    pixWdata = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [7:0]    rdData;
  logic          busy, done;

  int errors = 0;
  int checks = 0;
  int img [NPIX];
  int gm  [NPIX];
  int expAddr [$];
  int expVal  [$];
  string curTag = "";
  bit [31:0] lcg = 32'h1234_5678;
  event monGo, monDone;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_deblock #(.BLK_COLS(BC), .BLK_ROWS(BR)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .cfgWe(cfgWe), .cfgStrength(cfgStrength),
    .pixWe(pixWe), .pixAddr(pixAddr), .pixWdata(pixWdata), .rdAddr(rdAddr),
    .rdData(rdData), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nextRand();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'(lcg[23:16]);
  endfunction

  function automatic int clip8(input int v);
    return (v < 0) ? 0 : ((v > 255) ? 255 : v);
  endfunction

  // golden segment model, written from R5 R6 R7
  task automatic gSeg(input int ia, input int ib, input int ic, input int id, input int s);
    int a, b, c, dd, d, ad, m, d1, d2, lim;
    a = gm[ia]; b = gm[ib]; c = gm[ic]; dd = gm[id];
    d  = (a - 4*b + 4*c - dd) >>> 3;
    ad = (d < 0) ? -d : d;
    if (ad < s)          m = ad;
    else if (ad < 2*s)   m = 2*s - ad;
    else                 m = 0;
    d1  = (d < 0) ? -m : m;
    d2  = (a - dd) >>> 2;
    lim = m / 2;
    if (d2 > lim)  d2 = lim;
    if (d2 < -lim) d2 = -lim;
    gm[ia] = clip8(a - d2);
    gm[ib] = clip8(b + d1);
    gm[ic] = clip8(c - d1);
    gm[id] = clip8(dd + d2);
  endtask

  // R8: horizontal boundaries first, then vertical
  task automatic goldenPass(input int s);
    for (int k = 1; k < BR; k++)
      for (int x = 0; x < W; x++)
        gSeg((8*k-2)*W + x, (8*k-1)*W + x, (8*k)*W + x, (8*k+1)*W + x, s);
    for (int k = 1; k < BC; k++)
      for (int y = 0; y < H; y++)
        gSeg(y*W + 8*k-2, y*W + 8*k-1, y*W + 8*k, y*W + 8*k+1, s);
  endtask

  task automatic fillImage(input int kind);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        case (kind)
          0: img[y*W+x] = nextRand();
          1: img[y*W+x] = ((y/8)*BC + x/8) * 55 + 30 + (x % 8);
          2: begin
               int r;
               r = nextRand() % 4;
               img[y*W+x] = (r == 0) ? 0 : ((r == 1) ? 250 : ((r == 2) ? 255 : 5));
             end
          default: img[y*W+x] = (x*8 + y) % 256;
        endcase
        gm[y*W+x] = img[y*W+x];
      end
  endtask

  // R10: host load through the write port
  task automatic loadImage();
    for (int a = 0; a < NPIX; a++) begin
      @(negedge clk);
      pixWe = 1'b1; pixAddr = AW'(a); pixWdata = 8'(img[a]);
    end
    @(negedge clk);
    pixWe = 1'b0;
  endtask

  task automatic setStrength(input int s);
    @(negedge clk);
    cfgWe = 1'b1; cfgStrength = 8'(s);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pushExpected();
    for (int a = 0; a < NPIX; a++) begin
      expAddr.push_back(a);
      expVal.push_back(gm[a]);
    end
  endtask

  // R2 R3 timing; optional disturbance mid-pass or inputs shared with start
  task automatic startAndWait(input bit disturb, input bit same, input int sa,
                              input int sv, input int ss, input string tag);
    int busyCnt, doneAt, doneCnt;
    busyCnt = 0; doneAt = 0; doneCnt = 0;
    @(negedge clk);
    start = 1'b1;
    if (same) begin
      pixWe = 1'b1; pixAddr = AW'(sa); pixWdata = 8'(sv);
      cfgWe = 1'b1; cfgStrength = 8'(ss);
    end
    @(negedge clk);
    start = 1'b0; pixWe = 1'b0; cfgWe = 1'b0;
    for (int n = 1; n <= NSEG + 4; n++) begin
      if (busy) busyCnt++;
      if (done) begin
        doneCnt++;
        if (doneAt == 0) doneAt = n;
      end
      if (disturb && n == 3) begin
        start = 1'b1;
        pixWe = 1'b1; pixAddr = AW'(3*W + 3); pixWdata = 8'(~img[3*W+3]);
        cfgWe = 1'b1; cfgStrength = 8'd200;
      end else begin
        start = 1'b0; pixWe = 1'b0; cfgWe = 1'b0;
      end
      @(negedge clk);
    end
    chk(busyCnt == NSEG, {"R2 busy cycles ", tag}, busyCnt, NSEG);
    chk(doneAt == NSEG + 1, {"R2 R3 done cycle ", tag}, doneAt, NSEG + 1);
    chk(doneCnt == 1, {"R2 done pulse count ", tag}, doneCnt, 1);
  endtask

  task automatic runCheck();
    ->monGo;
    @(monDone);
  endtask

  // monitor: pops expected pixels and compares against the read port (R11)
  initial begin
    forever begin
      @(monGo);
      while (expAddr.size() > 0) begin
        int a, v;
        a = expAddr.pop_front();
        v = expVal.pop_front();
        @(negedge clk);
        rdAddr = AW'(a);
        #1;
        chk(int'(rdData) == v, {"R11 pixel ", curTag}, int'(rdData), v);
      end
      ->monDone;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    // R1 reset state
    #(CLK_PERIOD*2);
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    chk(done == 1'b0, "R1 done in reset", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);

    // T1: random tile, moderate strength (R4 R5 R6 R8)
    curTag = "R4 R5 R6 R8 random";
    fillImage(0); loadImage(); setStrength(12);
    goldenPass(12); pushExpected();
    startAndWait(1'b0, 1'b0, 0, 0, 0, "T1");
    runCheck();
    @(negedge clk); rdAddr = '0; #1;
    chk(int'(rdData) == img[0], "R4 border corner untouched", int'(rdData), img[0]);
    rdAddr = AW'((H-1)*W + W-1); #1;
    chk(int'(rdData) == img[(H-1)*W+W-1], "R4 far corner untouched", int'(rdData), img[(H-1)*W+W-1]);

    // T2: flat blocks, ramp region (R5 R6)
    curTag = "R5 R6 blocky";
    fillImage(1); loadImage(); setStrength(40);
    goldenPass(40); pushExpected();
    startAndWait(1'b0, 1'b0, 0, 0, 0, "T2");
    runCheck();

    // T3: extreme values, clipping (R7)
    curTag = "R7 spiky";
    fillImage(2); loadImage(); setStrength(255);
    goldenPass(255); pushExpected();
    startAndWait(1'b0, 1'b0, 0, 0, 0, "T3");
    runCheck();

    // T4: zero strength leaves tile unchanged (R5)
    curTag = "R5 zero strength";
    fillImage(3); loadImage(); setStrength(0);
    goldenPass(0); pushExpected();
    startAndWait(1'b0, 1'b0, 0, 0, 0, "T4");
    runCheck();

    // T5: start, strength write and pixel write while busy are ignored (R3 R9 R10)
    curTag = "R3 R9 R10 busy writes ignored";
    fillImage(0); loadImage(); setStrength(20);
    goldenPass(20); pushExpected();
    startAndWait(1'b1, 1'b0, 0, 0, 0, "T5");
    runCheck();

    // T6: pixel and strength writes in the same cycle as start are used (R9 R10)
    curTag = "R9 R10 same cycle as start";
    fillImage(1); loadImage(); setStrength(5);
    gm[7*W+8] = 200;
    goldenPass(30); pushExpected();
    startAndWait(1'b0, 1'b1, 7*W+8, 200, 30, "T6");
    runCheck();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule